// File: doc/BRIEF.md
# Cartridge Bank-Switching Address Mapper

This block sits between a CPU, a picture processor and the cartridge memories. It holds the bank-select registers. It turns 16-bit CPU addresses into physical program-memory addresses and 14-bit pattern addresses into physical pattern-memory addresses. The CPU loads the registers through a write strobe with address and data buses. The block also drives the nametable mirroring select. Interrupt timing is not part of this block.

The upper half of the CPU map is split into four 8 KB program windows. Three of them can be switched independently. The fourth is always tied to the highest program bank. Pattern space is split into eight 1 KB slots, and each slot has its own bank register. The program and pattern bank counts are power-of-two parameters. A bank number beyond the count wraps by dropping its upper bits. A parameter selects whether pattern memory is ROM or writable RAM.

Address translation is purely combinational from the current register contents. A register write at one clock edge is therefore reflected in the very next cycle's translated addresses.

Top module: `cart_bank_mapper`

## Requirements
- R1: When `cpu_addr[15]` is 1, `prg_sel` is 1, and `prg_addr` = {bank, `cpu_addr[12:0]`}. The bank comes from the window in `cpu_addr[14:13]`: 0, 1 and 2 use program registers 0, 1 and 2, and 3 always uses bank `PRG_BANKS-1`. When `cpu_addr[15]` is 0, `prg_sel` is 0.
- R2: A CPU write with `cpu_addr[15:12]` equal to 0x8, 0xA or 0xC loads `cpu_wdata` into program register 0, 1 or 2 respectively.
- R3: After reset, program registers 0, 1 and 2 hold 0, 1 and 2, every pattern register holds 0, and `mirror_horiz` is 0.
- R4: `chr_addr` = {bank, `ppu_addr[9:0]`}, where bank is the pattern register picked by `ppu_addr[12:10]`. A CPU write with `cpu_addr[15:12]` = 0xB loads `cpu_wdata` into the pattern register numbered `cpu_addr[2:0]`.
- R5: A CPU write to exactly 0x9000 or 0x9001 sets `mirror_horiz` to `cpu_wdata[7]`. A value of 1 means horizontal mirroring and 0 means vertical.
- R6: A program bank value v maps to bank v mod `PRG_BANKS`, and a pattern bank value v maps to bank v mod `CHR_BANKS`.
- R7: `chr_sel` is 1 exactly when `ppu_addr[13]` is 0. `chr_we` is 1 only when `CHR_IS_RAM` is 1, `ppu_wr` is 1 and `chr_sel` is 1. With pattern ROM, `chr_we` stays 0.
- R8: `cpu_wr_ack` is 1 in the same cycle as `cpu_wr` only for the decoded addresses of R2, R4 and R5. Writes to any other address leave every register and every output mapping unchanged.
- R9: The cycle after a register write, the translated addresses already use the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 16 | CPU address (write decode and read translation) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr_ack | output | 1 | Write hit a decoded register |
| prg_sel | output | 1 | CPU address falls in program space |
| prg_addr | output | $clog2(PRG_BANKS)+13 | Physical program-memory address |
| ppu_addr | input | 14 | Picture processor address |
| ppu_wr | input | 1 | Picture processor write strobe |
| chr_sel | output | 1 | Address falls in pattern space |
| chr_addr | output | $clog2(CHR_BANKS)+10 | Physical pattern-memory address |
| chr_we | output | 1 | Pattern RAM write enable |
| mirror_horiz | output | 1 | 1 selects horizontal mirroring, 0 vertical |

## Verification
The bench writes bank values across the full 8-bit range into every program and pattern register. It checks that values above the bank count wrap. A design that kept an extra bit, or used the wrong bit slice, would point into a bank that does not exist.

It sweeps the fixed top window after every change. A design that let a register steer that window would move the reset vector.

It fires writes at near-miss addresses such as 0x9002, 0xD000 and 0xE000, at the IRQ-range offsets, and below 0x8000. A loose decoder would then acknowledge the write or corrupt a bank.

A second instance built with pattern RAM has a bench RAM model. Data written through one slot is read back through another slot mapped to the same bank. A wrong slot index or write enable would return stale data, and the ROM build must never assert its write enable.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    typedef logic [7:0] bank_t;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_PRG,
        WR_CHR,
        WR_MIRROR
    } wr_kind_e;

    typedef struct packed {
        bank_t [2:0] prg;
        bank_t [7:0] chr;
        logic        mirror_h;
    } map_regs_t;

    function automatic map_regs_t regs_reset_value();
        map_regs_t r;
        r = '0;
        for (int i = 0; i < 3; i++) begin
            r.prg[i] = bank_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/mapper_wr_decode.sv
module mapper_wr_decode
    import mapper_pkg::*;
(
    input  logic        wr,
    input  logic [15:0] addr,
    output wr_kind_e    kind,
    output logic [1:0]  prg_idx,
    output logic        accept
);

    always_comb begin
        kind    = WR_NONE;
        prg_idx = 2'd0;
        case (addr[15:12])
            4'h8: begin kind = WR_PRG; prg_idx = 2'd0; end
            4'hA: begin kind = WR_PRG; prg_idx = 2'd1; end
            4'hC: begin kind = WR_PRG; prg_idx = 2'd2; end
            4'hB: kind = WR_CHR;
            4'h9: if (addr[11:1] == 11'd0) kind = WR_MIRROR;
            default: kind = WR_NONE;
        endcase
        accept = wr && (kind != WR_NONE);
    end

endmodule

// File: rtl/mapper_regs.sv
module mapper_regs
    import mapper_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept,
    input  wr_kind_e  kind,
    input  logic [1:0] prg_idx,
    input  logic [2:0] slot,
    input  bank_t     wdata,
    output map_regs_t regs_q
);

    map_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        if (accept) begin
            case (kind)
                WR_PRG:    regs_d.prg[prg_idx] = wdata;
                WR_CHR:    regs_d.chr[slot]    = wdata;
                WR_MIRROR: regs_d.mirror_h     = wdata[7];
                default:   regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= regs_reset_value();
        else        regs_q <= regs_d;
    end

    AST_PRG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == WR_PRG) |=> regs_q.prg[$past(prg_idx)] == $past(wdata)); // R2
    AST_CHR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == WR_CHR) |=> regs_q.chr[$past(slot)] == $past(wdata)); // R4
    AST_HOLD_UNACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(regs_q)); // R8

endmodule

// File: rtl/mapper_prg_xlate.sv
module mapper_prg_xlate
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS = 16,
    localparam int PBW = $clog2(PRG_BANKS),
    localparam int PAW = PBW + 13
) (
    input  logic [15:0]  cpu_addr,
    input  bank_t [2:0]  prg_bank,
    output logic         prg_sel,
    output logic [PAW-1:0] prg_addr
);

    logic [1:0]     win;
    logic [PBW-1:0] bank;
    logic           unused_ok;

    always_comb begin
        win = cpu_addr[14:13];
        if (win == 2'd3) bank = PBW'(PRG_BANKS - 1);
        else             bank = prg_bank[win][PBW-1:0];
        prg_addr = {bank, cpu_addr[12:0]};
        prg_sel  = cpu_addr[15];
    end

    assign unused_ok = ^prg_bank;

endmodule

// File: rtl/mapper_chr_xlate.sv
module mapper_chr_xlate
    import mapper_pkg::*;
#(
    parameter int CHR_BANKS  = 32,
    parameter bit CHR_IS_RAM = 1'b0,
    localparam int CBW = $clog2(CHR_BANKS),
    localparam int CAW = CBW + 10
) (
    input  logic [13:0]    ppu_addr,
    input  logic           ppu_wr,
    input  bank_t [7:0]    chr_bank,
    output logic           chr_sel,
    output logic [CAW-1:0] chr_addr,
    output logic           chr_we
);

    logic [CBW-1:0] bank;
    logic           unused_ok;

    always_comb begin
        bank     = chr_bank[ppu_addr[12:10]][CBW-1:0];
        chr_addr = {bank, ppu_addr[9:0]};
        chr_sel  = !ppu_addr[13];
    end

    generate
        if (CHR_IS_RAM) begin : g_ram
            assign chr_we = ppu_wr && chr_sel;
        end else begin : g_rom
            assign chr_we = 1'b0;
        end
    endgenerate

    assign unused_ok = ^{chr_bank, ppu_wr};

endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_BANKS  = 16,
    parameter int CHR_BANKS  = 32,
    parameter bit CHR_IS_RAM = 1'b0,
    localparam int PAW = $clog2(PRG_BANKS) + 13,
    localparam int CAW = $clog2(CHR_BANKS) + 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_wr,
    input  logic [15:0]    cpu_addr,
    input  logic [7:0]     cpu_wdata,
    output logic           cpu_wr_ack,
    output logic           prg_sel,
    output logic [PAW-1:0] prg_addr,
    input  logic [13:0]    ppu_addr,
    input  logic           ppu_wr,
    output logic           chr_sel,
    output logic [CAW-1:0] chr_addr,
    output logic           chr_we,
    output logic           mirror_horiz
);

    wr_kind_e   kind;
    logic [1:0] prg_idx;
    map_regs_t  regs_q;

    mapper_wr_decode u_dec (
        .wr      (cpu_wr),
        .addr    (cpu_addr),
        .kind    (kind),
        .prg_idx (prg_idx),
        .accept  (cpu_wr_ack)
    );

    mapper_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (cpu_wr_ack),
        .kind    (kind),
        .prg_idx (prg_idx),
        .slot    (cpu_addr[2:0]),
        .wdata   (cpu_wdata),
        .regs_q  (regs_q)
    );

    mapper_prg_xlate #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .cpu_addr (cpu_addr),
        .prg_bank (regs_q.prg),
        .prg_sel  (prg_sel),
        .prg_addr (prg_addr)
    );

    mapper_chr_xlate #(.CHR_BANKS(CHR_BANKS), .CHR_IS_RAM(CHR_IS_RAM)) u_chr (
        .ppu_addr (ppu_addr),
        .ppu_wr   (ppu_wr),
        .chr_bank (regs_q.chr),
        .chr_sel  (chr_sel),
        .chr_addr (chr_addr),
        .chr_we   (chr_we)
    );

    assign mirror_horiz = regs_q.mirror_h;

    AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (prg_addr[PAW-1:13] == '1)); // R1
    AST_PRG_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        prg_addr[12:0] == cpu_addr[12:0]); // R1
    AST_CHR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[9:0] == ppu_addr[9:0]); // R4
    AST_MIRROR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:1] == 15'h4800) |=> mirror_horiz == $past(cpu_wdata[7])); // R5
    AST_ACK_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr_ack |-> (cpu_wr && cpu_addr[15])); // R8
    AST_NO_WE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ppu_wr || ppu_addr[13]) |-> !chr_we); // R7

endmodule

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;

    localparam int A_PRG = 8,  A_CHR = 32;
    localparam int B_PRG = 16, B_CHR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic [13:0] ppu_addr = 14'h0;
    logic        ppu_wr = 1'b0;
    logic [7:0]  ppu_wdata = 8'h0;

    logic        a_ack, a_psel, a_csel, a_we, a_mir;
    logic [15:0] a_paddr;
    logic [14:0] a_caddr;
    logic        b_ack, b_psel, b_csel, b_we, b_mir;
    logic [16:0] b_paddr;
    logic [12:0] b_caddr;

    int errors = 0, checks = 0;
    int exp_prg [3];
    int exp_chr [8];
    int exp_mir;
    logic [7:0] ram [8192];
    logic [7:0] rdback;

    always #5 clk = ~clk;

    cart_bank_mapper #(.PRG_BANKS(A_PRG), .CHR_BANKS(A_CHR), .CHR_IS_RAM(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr_ack(a_ack), .prg_sel(a_psel), .prg_addr(a_paddr), .ppu_addr(ppu_addr),
        .ppu_wr(ppu_wr), .chr_sel(a_csel), .chr_addr(a_caddr), .chr_we(a_we), .mirror_horiz(a_mir));

    cart_bank_mapper #(.PRG_BANKS(B_PRG), .CHR_BANKS(B_CHR), .CHR_IS_RAM(1'b1)) dut_ram (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wr_ack(b_ack), .prg_sel(b_psel), .prg_addr(b_paddr), .ppu_addr(ppu_addr),
        .ppu_wr(ppu_wr), .chr_sel(b_csel), .chr_addr(b_caddr), .chr_we(b_we), .mirror_horiz(b_mir));

    always @(posedge clk) if (b_we) ram[b_caddr] <= ppu_wdata;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit decoded(input logic [15:0] a);
        return (a[15:12] == 4'h8) || (a[15:12] == 4'hA) || (a[15:12] == 4'hB) ||
               (a[15:12] == 4'hC) || (a == 16'h9000) || (a == 16'h9001);
    endfunction

    // CPU register write; expected state follows R2, R4, R5, R8
    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        #1;
        check({req, " ack"}, int'(a_ack), int'(decoded(a)));
        check({req, " ack ram"}, int'(b_ack), int'(decoded(a)));
        @(negedge clk);
        cpu_wr = 1'b0;
        case (a[15:12])
            4'h8: exp_prg[0] = d;
            4'hA: exp_prg[1] = d;
            4'hC: exp_prg[2] = d;
            4'hB: exp_chr[a[2:0]] = d;
            4'h9: if (a[11:1] == 11'd0) exp_mir = d[7];
            default: ;
        endcase
    endtask

    // Check one program window (R1, R6, R9)
    task automatic check_win(input int w, input int off, input string req);
        int ba, bb;
        cpu_addr = 16'h8000 + 16'(w * 16'h2000) + 16'(off);
        #1;
        ba = (w == 3) ? A_PRG - 1 : exp_prg[w] % A_PRG;
        bb = (w == 3) ? B_PRG - 1 : exp_prg[w] % B_PRG;
        check({req, " prg"}, int'(a_paddr), ba * 8192 + off);
        check({req, " prg ram"}, int'(b_paddr), bb * 8192 + off);
    endtask

    // Check one pattern slot (R4, R6, R9)
    task automatic check_slot(input int s, input int off, input string req);
        ppu_addr = 14'(s * 1024 + off);
        #1;
        check({req, " chr"}, int'(a_caddr), (exp_chr[s] % A_CHR) * 1024 + off);
        check({req, " chr ram"}, int'(b_caddr), (exp_chr[s] % B_CHR) * 1024 + off);
    endtask

    task automatic check_all(input string req);
        for (int w = 0; w < 4; w++) begin
            check_win(w, 0, req);
            check_win(w, 13'h1FFF, req);
            check_win(w, 13'h0ABC, req);
        end
        for (int s = 0; s < 8; s++) begin
            check_slot(s, 0, req);
            check_slot(s, 10'h3FF, req);
        end
        check({req, " mirror"}, int'(a_mir), exp_mir);
        check({req, " mirror ram"}, int'(b_mir), exp_mir);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        exp_prg = '{0, 1, 2};
        exp_chr = '{default: 0};
        exp_mir = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        check_all("R3 reset");

        // R1 prg_sel split at 0x8000
        cpu_addr = 16'h7FFF; #1;
        check("R1 sel low", int'(a_psel), 0);
        cpu_addr = 16'h8000; #1;
        check("R1 sel high", int'(a_psel), 1);

        // R2, R6, R9: sweep program registers through all three decode regions
        for (int v = 0; v < 256; v += 7) begin
            cpu_write(16'h8000 | 16'((v * 16'h123) & 16'h0FFF), 8'(v), "R2 prg0");
            check_win(0, v * 5 & 16'h1FFF, "R9 prg0 R6");
            cpu_write(16'hA000 | 16'((v * 16'h0F1) & 16'h0FFF), 8'(v + 3), "R2 prg1");
            check_win(1, v, "R9 prg1 R6");
            cpu_write(16'hC000 | 16'((v * 16'h3A7) & 16'h0FFF), 8'(255 - v), "R2 prg2");
            check_win(2, 16'h1FFF - v, "R9 prg2 R6");
            check_win(3, v, "R1 fixed");
        end

        // R4, R6: sweep pattern registers with varied upper address bits
        for (int v = 0; v < 256; v += 5) begin
            int s;
            s = (v / 5) % 8;
            cpu_write(16'hB000 | 16'((v << 3) & 16'h0FF8) | 16'(s), 8'(v * 3), "R4 chr");
            check_slot(s, v & 10'h3FF, "R4 R9 slot R6");
        end
        check_all("R4 after sweep");

        // R5 mirroring
        cpu_write(16'h9000, 8'h80, "R5 9000");
        check("R5 horiz", int'(a_mir), 1);
        cpu_write(16'h9001, 8'h7F, "R5 9001");
        check("R5 vert", int'(b_mir), 0);
        cpu_write(16'h9001, 8'hC0, "R5 9001 set");
        check("R5 horiz2", int'(a_mir), 1);

        // R8 unmapped writes ignored
        cpu_write(16'h9002, 8'h00, "R8 9002");
        cpu_write(16'h9003, 8'h00, "R8 9003");
        cpu_write(16'h9004, 8'h00, "R8 9004");
        cpu_write(16'h9800, 8'h00, "R8 9800");
        cpu_write(16'hD000, 8'h55, "R8 D000");
        cpu_write(16'hE001, 8'h55, "R8 E001");
        cpu_write(16'hFFFF, 8'h55, "R8 FFFF");
        cpu_write(16'h7000, 8'h55, "R8 7000");
        cpu_write(16'h0800, 8'h55, "R8 0800");
        check_all("R8 unchanged");

        // R7 write enables
        ppu_wr = 1'b1;
        ppu_addr = 14'h0123; #1;
        check("R7 rom we", int'(a_we), 0);
        check("R7 ram we", int'(b_we), 1);
        check("R7 sel", int'(b_csel), 1);
        ppu_addr = 14'h2123; #1;
        check("R7 ram we outside", int'(b_we), 0);
        check("R7 sel outside", int'(a_csel), 0);
        ppu_wr = 1'b0;
        ppu_addr = 14'h0123; #1;
        check("R7 ram we idle", int'(b_we), 0);

        // R7, R4: RAM write through slot 0, read back through slot 5 on same bank
        cpu_write(16'hB000, 8'd6, "R4 slot0");
        cpu_write(16'hB005, 8'd14, "R4 slot5 wraps to 6");
        @(negedge clk);
        ppu_addr = 14'h0042; ppu_wdata = 8'hA5; ppu_wr = 1'b1;
        @(negedge clk);
        ppu_wr = 1'b0;
        ppu_addr = 14'(5 * 1024 + 16'h42); #1;
        rdback = ram[b_caddr];
        check("R7 ram readback", int'(rdback), 8'hA5);
        check("R6 slot5 addr", int'(b_caddr), 6 * 1024 + 16'h42);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule